// File: doc/BRIEF.md
# Fractional Ratio Clock Divider

This block divides its input clock by a programmable ratio that need not be an integer. It emits a one-cycle strobe at the end of each divided period. The ratio comes from three loaded values, P1, P2 and P3. Their average ratio is 4 + P1/128 + P2/(128·P3), so the step between neighbouring ratios is 1/(128·P3).

Each period lasts a whole number of input cycles. A first-order residue accumulator chooses, period by period, between the integer part and the integer part plus one. Over many periods the average length then equals the exact ratio.

A power-of-two post-divider follows the fractional stage. It passes through one strobe in every 2^k. A new setting is held as pending until the current period ends, so no period is ever cut short. An invalid setting is refused, and an error flag reports the refusal.

Top module: `frac_ratio_divider`

## Requirements
- R1: During reset and on the first cycle after it, both strobes and `cfg_err` are low. The default setting (P1=0, P2=0, P3=1, k=0) is active. The first `frac_tick` appears 4 cycles after reset is released.
- R2: Define I = 4 + floor(P1/128), F = (P1 mod 128)·P3 + P2 and D = 128·P3. The first period under a newly active setting lasts I cycles and clears the residue. At each later period end, F is added to the residue. If the sum is at least D, D is subtracted and the next period lasts I+1 cycles; otherwise it lasts I cycles.
- R3: Measured from the end of the first period under a setting, the next D periods together last exactly (512+P1)·P3 + P2 cycles.
- R4: A load is valid when P3 is nonzero, P3 is below 1048575 (hex FFFFF), and P2 < P3. After an invalid load, `cfg_err` reads 1 from the next cycle and both the active and the pending settings stay unchanged. After a valid load, `cfg_err` reads 0.
- R5: A valid load becomes active only at the next period end. The period in progress completes at the length it would have had without the load.
- R6: When several valid loads arrive before a period end, the last one is the setting that becomes active.
- R7: With k=0, `out_tick` is high on the same cycle as every `frac_tick`. With k>0, `out_tick` is high on every 2^k-th `frac_tick`, counted from the point where a setting became active. The strobe that ends the old period is still judged with the old k.
- R8: `frac_tick` is high for one cycle at a time and is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load strobe for the four setting fields |
| cfg_p1 | input | 18 | P1: integer and coarse-fraction field of the ratio |
| cfg_p2 | input | 20 | P2: fine-fraction numerator |
| cfg_p3 | input | 20 | P3: fine-fraction denominator |
| cfg_k | input | 3 | Post-divider exponent k, dividing by 2^k |
| frac_tick | output | 1 | Strobe at the end of each fractional period |
| out_tick | output | 1 | Strobe after the post-divider |
| cfg_err | output | 1 | High after a refused load, low after an accepted one |

## Verification
The bench measures the cycle count over a full residue cycle for two settings. A design that used the wrong denominator, or lost the carry out of the residue compare, would drift from (512+P1)·P3 + P2.

It loads settings right after a period end to check the period in progress, and it loads twice in a row to check which load wins. A design that applied a setting at once would produce a runt period. A design that let the first of two loads win would produce the wrong first period under the new setting.

It sends refused triples (P2 equal to P3, and P3 of all ones) and checks that period lengths carry on unchanged. Random loads, with settings landing on the boundary cycle, exercise the post-divider restart at a change of k. A post-divider that kept its count across the change would misplace `out_tick`.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  localparam int P1_W      = 18;
  localparam int P3_W      = 20;
  localparam int K_W       = 3;
  localparam int FRAC_BITS = 7;
  localparam int BASE_DIV  = 4;
  localparam int FR_W      = P3_W + FRAC_BITS;
  localparam int LEN_W     = P1_W - FRAC_BITS + 1;
  localparam int PC_W      = (1 << K_W) - 1;

  typedef struct packed {
    logic [P1_W-1:0] p1;
    logic [P3_W-1:0] p2;
    logic [P3_W-1:0] p3;
    logic [K_W-1:0]  k;
  } ratio_cfg_t;

  function automatic logic [LEN_W-1:0] int_part(input ratio_cfg_t c);
    return LEN_W'(c.p1 >> FRAC_BITS) + LEN_W'(BASE_DIV);
  endfunction

  function automatic logic [FR_W-1:0] frac_part(input ratio_cfg_t c);
    return FR_W'(c.p1[FRAC_BITS-1:0]) * FR_W'(c.p3) + FR_W'(c.p2);
  endfunction

  function automatic logic [FR_W-1:0] denom(input ratio_cfg_t c);
    return {c.p3, {FRAC_BITS{1'b0}}};
  endfunction

  function automatic logic cfg_valid(input ratio_cfg_t c);
    return (c.p3 != '0) && (c.p3 != '1) && (c.p2 < c.p3);
  endfunction
endpackage

// File: rtl/fdiv_cfg_bank.sv
module fdiv_cfg_bank import fdiv_pkg::*; #(
  parameter ratio_cfg_t DEF = '0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load_i,
  input  ratio_cfg_t cfg_i,
  input  logic       bound_i,
  output ratio_cfg_t act_o,
  output ratio_cfg_t next_o,
  output logic       take_o,
  output logic       err_o
);
  ratio_cfg_t pend_q;
  logic       pv_q;
  logic       ok;

  assign ok     = cfg_valid(cfg_i);
  assign take_o = pv_q;
  assign next_o = pv_q ? pend_q : act_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_o  <= DEF;
      pend_q <= DEF;
      pv_q   <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      if (bound_i && pv_q) act_o <= pend_q;
      if (load_i && ok) begin
        pend_q <= cfg_i;
        pv_q   <= 1'b1;
      end else if (bound_i) begin
        pv_q   <= 1'b0;
      end
      if (load_i) err_o <= !ok;
    end
  end

  // R5: the active setting moves only at a period end with a pending load
  p_active_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !(bound_i && pv_q) |=> $stable(act_o));

  // R4: a refused load flags an error and leaves the pending setting alone
  p_reject_keeps_r4: assert property (@(posedge clk) disable iff (rst)
    (load_i && !ok) |=> (err_o && $stable(pend_q)));

  // R4: an accepted load clears the flag
  p_accept_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (load_i && ok) |=> !err_o);
endmodule

// File: rtl/fdiv_period_gen.sv
module fdiv_period_gen import fdiv_pkg::*; #(
  parameter ratio_cfg_t DEF = '0
) (
  input  logic       clk,
  input  logic       rst,
  input  ratio_cfg_t next_i,
  input  logic       take_i,
  output logic       end_o,
  output logic       tick_o
);
  logic [LEN_W-1:0] cnt_q, len_q, ipart;
  logic [FR_W-1:0]  res_q, fpart, dval;
  logic [FR_W:0]    sum;
  logic             carry;

  always_comb begin
    ipart = int_part(next_i);
    fpart = frac_part(next_i);
    dval  = denom(next_i);
    sum   = {1'b0, res_q} + {1'b0, fpart};
    carry = (sum >= {1'b0, dval});
  end

  assign end_o = (cnt_q == len_q - LEN_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      len_q  <= int_part(DEF);
      res_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= end_o;
      if (end_o) begin
        cnt_q <= '0;
        if (take_i) begin
          len_q <= ipart;
          res_q <= '0;
        end else begin
          len_q <= ipart + LEN_W'(carry);
          res_q <= carry ? FR_W'(sum - {1'b0, dval}) : sum[FR_W-1:0];
        end
      end else begin
        cnt_q <= cnt_q + LEN_W'(1);
      end
    end
  end

  // R8: strobes are separated by at least one low cycle
  p_min_gap_r8: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);

  // R2: no period shorter than the base division
  p_len_floor_r2: assert property (@(posedge clk) disable iff (rst)
    len_q >= LEN_W'(BASE_DIV));

  // R2: the residue stays below the active denominator
  p_res_bound_r2: assert property (@(posedge clk) disable iff (rst)
    !take_i |-> (res_q < dval));
endmodule

// File: rtl/fdiv_post_div.sv
module fdiv_post_div import fdiv_pkg::*; (
  input  logic           clk,
  input  logic           rst,
  input  logic           stb_i,
  input  logic           clr_i,
  input  logic [K_W-1:0] k_i,
  output logic           out_o
);
  logic [PC_W-1:0] pc_q, mask;

  assign mask = ~({PC_W{1'b1}} << k_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      out_o <= 1'b0;
    end else begin
      out_o <= stb_i && (pc_q == mask);
      if (stb_i) begin
        if (clr_i || (pc_q == mask)) pc_q <= '0;
        else                         pc_q <= pc_q + PC_W'(1);
      end
    end
  end

  // R7: a post-divided strobe only follows a fractional strobe
  p_out_needs_stb_r7: assert property (@(posedge clk) disable iff (rst)
    out_o |-> $past(stb_i));

  // R7: the strobe count never exceeds the active modulus
  p_cnt_range_r7: assert property (@(posedge clk) disable iff (rst)
    pc_q <= mask);
endmodule

// File: rtl/frac_ratio_divider.sv
module frac_ratio_divider import fdiv_pkg::*; #(
  parameter int DEF_P1 = 0,
  parameter int DEF_P2 = 0,
  parameter int DEF_P3 = 1,
  parameter int DEF_K  = 0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_load,
  input  logic [P1_W-1:0] cfg_p1,
  input  logic [P3_W-1:0] cfg_p2,
  input  logic [P3_W-1:0] cfg_p3,
  input  logic [K_W-1:0]  cfg_k,
  output logic            frac_tick,
  output logic            out_tick,
  output logic            cfg_err
);
  localparam ratio_cfg_t DEF_CFG = '{p1: P1_W'(DEF_P1), p2: P3_W'(DEF_P2),
                                     p3: P3_W'(DEF_P3), k: K_W'(DEF_K)};

  ratio_cfg_t in_cfg, act_cfg, nxt_cfg;
  logic       take, bound;

  assign in_cfg = '{p1: cfg_p1, p2: cfg_p2, p3: cfg_p3, k: cfg_k};

  fdiv_cfg_bank #(.DEF(DEF_CFG)) cfg_i (
    .clk(clk), .rst(rst), .load_i(cfg_load), .cfg_i(in_cfg), .bound_i(bound),
    .act_o(act_cfg), .next_o(nxt_cfg), .take_o(take), .err_o(cfg_err)
  );

  fdiv_period_gen #(.DEF(DEF_CFG)) per_i (
    .clk(clk), .rst(rst), .next_i(nxt_cfg), .take_i(take),
    .end_o(bound), .tick_o(frac_tick)
  );

  fdiv_post_div post_i (
    .clk(clk), .rst(rst), .stb_i(bound), .clr_i(bound && take),
    .k_i(act_cfg.k), .out_o(out_tick)
  );
endmodule

// File: tb/frac_ratio_divider_tb_top.sv
module frac_ratio_divider_tb_top;
  logic        clk = 1'b0, rst = 1'b1, cfg_load = 1'b0;
  logic [17:0] cfg_p1 = '0;
  logic [19:0] cfg_p2 = '0, cfg_p3 = 20'd1;
  logic [2:0]  cfg_k = '0;
  logic        frac_tick, out_tick, cfg_err;
  int          checks = 0, fails = 0, cyc = 0;
  bit          done = 1'b0, prev_frac = 1'b0;

  always #5 clk = ~clk;

  frac_ratio_divider dut_i (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_p1(cfg_p1), .cfg_p2(cfg_p2),
    .cfg_p3(cfg_p3), .cfg_k(cfg_k), .frac_tick(frac_tick), .out_tick(out_tick),
    .cfg_err(cfg_err)
  );

  function automatic longint ipt(longint p1);
    return 4 + p1 / 128;
  endfunction
  function automatic longint fpt(longint p1, longint p2, longint p3);
    return (p1 % 128) * p3 + p2;
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // behavioural reference: active/pending settings, residue, period counter
  longint m_cnt, m_len, m_res, m_pc;
  longint a_p1, a_p2, a_p3, a_k, n_p1, n_p2, n_p3, n_k;
  bit     m_pv, e_frac, e_out, e_err;

  always @(posedge clk) begin : model
    bit endp, take, ok;
    longint mask, sum;
    cyc++;
    if (rst) begin
      m_cnt = 0; m_len = 4; m_res = 0; m_pc = 0; m_pv = 0;
      a_p1 = 0; a_p2 = 0; a_p3 = 1; a_k = 0;
      e_frac = 0; e_out = 0; e_err = 0;
    end else begin
      endp = (m_cnt == m_len - 1);
      take = endp && m_pv;
      mask = (64'd1 << a_k) - 1;
      e_frac = endp;
      e_out  = endp && (m_pc == mask);
      if (endp) begin
        if (take) m_pc = 0;
        else m_pc = (m_pc == mask) ? 0 : m_pc + 1;
        m_cnt = 0;
        if (take) begin
          a_p1 = n_p1; a_p2 = n_p2; a_p3 = n_p3; a_k = n_k;
          m_len = ipt(a_p1); m_res = 0; m_pv = 0;
        end else begin
          sum = m_res + fpt(a_p1, a_p2, a_p3);
          if (sum >= 128 * a_p3) begin
            m_len = ipt(a_p1) + 1; m_res = sum - 128 * a_p3;
          end else begin
            m_len = ipt(a_p1); m_res = sum;
          end
        end
      end else begin
        m_cnt++;
      end
      if (cfg_load) begin
        ok = (cfg_p3 != 0) && (cfg_p3 != 20'hFFFFF) && (cfg_p2 < cfg_p3);
        e_err = !ok;
        if (ok) begin
          n_p1 = cfg_p1; n_p2 = cfg_p2; n_p3 = cfg_p3; n_k = cfg_k; m_pv = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      chk(frac_tick == e_frac, "R2/R5/R6 frac_tick", frac_tick, e_frac);
      chk(out_tick == e_out, "R7 out_tick", out_tick, e_out);
      chk(cfg_err == e_err, "R4 cfg_err", cfg_err, e_err);
      chk(!(frac_tick && prev_frac), "R8 strobe gap", frac_tick && prev_frac, 0);
      prev_frac = frac_tick;
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: got cycle %0d expected below %0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic wait_tick();
    do @(negedge clk); while (!frac_tick);
  endtask

  task automatic load(longint p1, longint p2, longint p3, longint k);
    cfg_p1 = 18'(p1); cfg_p2 = 20'(p2); cfg_p3 = 20'(p3); cfg_k = 3'(k);
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic measure_avg(longint p1, longint p2, longint p3);
    int t0, t1;
    wait_tick();
    load(p1, p2, p3, 0);
    wait_tick();
    wait_tick();
    t0 = cyc;
    repeat (int'(128 * p3)) wait_tick();
    t1 = cyc;
    chk((t1 - t0) == (512 + p1) * p3 + p2, "R3 average ratio", t1 - t0, (512 + p1) * p3 + p2);
  endtask

  initial begin
    int c0, t0, n;
    repeat (3) @(negedge clk);
    chk(!frac_tick && !out_tick && !cfg_err, "R1 reset outputs", {frac_tick, out_tick, cfg_err}, 0);
    rst = 1'b0;
    c0 = cyc;
    wait_tick();
    chk((cyc - c0) == 4, "R1 first strobe", cyc - c0, 4);
    repeat (20) @(negedge clk);

    measure_avg(100, 3, 7);
    measure_avg(300, 0, 1);

    // R6: two consecutive valid loads, the second wins (I = 8 vs 4)
    wait_tick();
    cfg_p1 = 18'd0; cfg_p2 = 20'd0; cfg_p3 = 20'd1; cfg_k = 3'd0; cfg_load = 1'b1;
    @(negedge clk);
    cfg_p1 = 18'd512;
    @(negedge clk);
    cfg_load = 1'b0;
    wait_tick();
    t0 = cyc;
    wait_tick();
    chk((cyc - t0) == 8, "R6 last load wins", cyc - t0, 8);

    // R5: load I = 12 right after a boundary; current period keeps length 8
    load(1024, 0, 1, 0);
    wait_tick();
    chk((cyc - t0 - 8) == 8, "R5 period in progress", cyc - t0 - 8, 8);
    t0 = cyc;
    wait_tick();
    chk((cyc - t0) == 12, "R5 new period", cyc - t0, 12);

    // R4: refused triples keep the period at 12
    load(0, 5, 5, 0);
    chk(cfg_err == 1'b1, "R4 error on P2=P3", cfg_err, 1);
    load(0, 0, 20'hFFFFF, 0);
    chk(cfg_err == 1'b1, "R4 error on P3 max", cfg_err, 1);
    wait_tick();
    t0 = cyc;
    wait_tick();
    chk((cyc - t0) == 12, "R4 setting kept", cyc - t0, 12);

    // R7: k = 3 gives 8 outputs per 64 strobes
    load(0, 0, 1, 3);
    chk(cfg_err == 1'b0, "R4 error cleared", cfg_err, 0);
    wait_tick();
    n = 0;
    repeat (64) begin
      do begin
        @(negedge clk);
        if (out_tick) n++;
      end while (!frac_tick);
    end
    chk(n == 8, "R7 k=3 count", n, 8);
    load(0, 0, 1, 7);
    repeat (1100) @(negedge clk);

    // random loads, some refused, some at period ends
    for (int i = 0; i < 60; i++) begin
      longint p3 = $urandom_range(1, 50);
      longint p2 = ($urandom_range(0, 7) == 0) ? p3 : $urandom_range(0, int'(p3) - 1);
      load($urandom_range(0, 1023), p2, p3, $urandom_range(0, 3));
      repeat ($urandom_range(0, 30)) @(negedge clk);
    end
    repeat (200) @(negedge clk);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule